// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire

This block tracks in-flight instructions in program order in a circular table of sixteen slots. An instruction takes the slot at the tail when it is dispatched, and the block returns that slot number. Execution units then report results against the slot number in any order. Each slot holds the destination architectural register, the physical register to free, the PC, a store flag, a branch-dependency mask, and the result once it arrives.

Each cycle the block retires up to four finished slots, oldest first, starting at the head. Retirement stops at the first slot that is not finished. A retiring lane carries the destination register and the result for the architectural register file. It also carries the physical register to free and a flag that lets a waiting store proceed. A mispredicted branch is named by its tag bit. The oldest slot that carries that bit, and every slot after it, is dropped by pulling the tail back. A slot that finished with an exception never retires. When it reaches the head, the block reports its PC and empties the whole buffer.

All outputs depend only on the stored state, so a result that arrives in one cycle can retire in the next.

Top module: `rob_inorder`

## Requirements
- R1: After reset the buffer is empty: `disp_ready`=1, `disp_idx`=0, `ret_valid`=0 and `exc_valid`=0.
- R2: An accepted dispatch takes slot `disp_idx`, and successive accepted dispatches receive consecutive slot numbers modulo 16.
- R3: With 16 slots occupied, `disp_ready` is 0 and a dispatch request is ignored, so the slot count and `disp_idx` are unchanged.
- R4: Lane k of the retire port (bit k of `ret_valid`, field bits [k*W +: W] of each lane bus) carries the k-th oldest slot, and at most four slots retire per cycle.
- R5: Retirement stops at the first unfinished slot counted from the head, so `ret_valid` is always a run of ones starting at bit 0, and no finished slot behind a gap retires.
- R6: A retiring lane presents the slot's destination register, its result, its physical register and its store flag.
- R7: A flush with tag bit t removes the oldest slot whose mask has bit t set and every slot after it. The tail moves back to that slot, which the next dispatch reuses. Removed slots never retire.
- R8: A slot that finished with an exception does not retire. Older slots retire first. When the slot is at the head, `exc_valid`=1 and `exc_pc` is its PC for one cycle, and the buffer is then empty with `disp_idx` equal to that slot.
- R9: While `exc_valid` is 1, a flush request and a dispatch request in the same cycle have no effect.
- R10: A dispatch request in the same cycle as a flush request is not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_rd | input | AW | Destination architectural register |
| disp_preg | input | PW | Physical register freed on retire |
| disp_pc | input | PCW | Instruction PC |
| disp_store | input | 1 | Instruction is a store |
| disp_mask | input | BR_TAGS | Branches the instruction depends on |
| disp_ready | output | 1 | A free slot exists |
| disp_idx | output | log2(DEPTH) | Slot the next dispatch takes |
| cmp_valid | input | 1 | Completion write |
| cmp_idx | input | log2(DEPTH) | Slot being completed |
| cmp_data | input | DW | Result value |
| cmp_exc | input | 1 | Instruction raised an exception |
| flush_valid | input | 1 | Branch mispredict flush |
| flush_tag | input | log2(BR_TAGS) | Tag bit of the mispredicted branch |
| ret_valid | output | RW | Retire lane valid, run from bit 0 |
| ret_rd | output | RW*AW | Destination register per lane |
| ret_preg | output | RW*PW | Freed physical register per lane |
| ret_data | output | RW*DW | Result per lane |
| ret_store | output | RW | Store may proceed, per lane |
| exc_valid | output | 1 | Exception taken at the head |
| exc_pc | output | PCW | PC of the excepting instruction |

## Verification
The hardest case to reach is an exception slot that arrives at the head in the same cycle as competing requests. Older slots must drain first, and a flush and a dispatch must be ignored while the exception is taken. The stimulus completes younger slots and the excepting slot before the oldest one. As a result, one cycle retires a single lane and the next raises the exception. A tagged flush and a dispatch are driven in that exception cycle. The buffer is filled past its wrap point with a gap two slots from the head, which shows that retirement stops short and then resumes four-wide.

// File: rtl/rob_inorder.sv
module rob_inorder #(
  parameter int DEPTH   = 16,
  parameter int RW      = 4,
  parameter int AW      = 5,
  parameter int PW      = 6,
  parameter int DW      = 32,
  parameter int PCW     = 32,
  parameter int BR_TAGS = 4,
  localparam int IW     = $clog2(DEPTH),
  localparam int TW     = $clog2(BR_TAGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [AW-1:0]        disp_rd,
  input  logic [PW-1:0]        disp_preg,
  input  logic [PCW-1:0]       disp_pc,
  input  logic                 disp_store,
  input  logic [BR_TAGS-1:0]   disp_mask,
  output logic                 disp_ready,
  output logic [IW-1:0]        disp_idx,
  input  logic                 cmp_valid,
  input  logic [IW-1:0]        cmp_idx,
  input  logic [DW-1:0]        cmp_data,
  input  logic                 cmp_exc,
  input  logic                 flush_valid,
  input  logic [TW-1:0]        flush_tag,
  output logic [RW-1:0]        ret_valid,
  output logic [RW*AW-1:0]     ret_rd,
  output logic [RW*PW-1:0]     ret_preg,
  output logic [RW*DW-1:0]     ret_data,
  output logic [RW-1:0]        ret_store,
  output logic                 exc_valid,
  output logic [PCW-1:0]       exc_pc
);

  logic [IW:0]          head, tail, count, nret, fl_off;
  logic                 fl_hit, disp_fire;
  logic [AW-1:0]        e_rd   [DEPTH];
  logic [PW-1:0]        e_preg [DEPTH];
  logic [PCW-1:0]       e_pc   [DEPTH];
  logic [DW-1:0]        e_data [DEPTH];
  logic [BR_TAGS-1:0]   e_mask [DEPTH];
  logic [DEPTH-1:0]     e_store, e_done, e_exc;
  wire  [IW-1:0]        hidx = head[IW-1:0];

  assign count      = tail - head;
  assign disp_ready = (count != (IW+1)'(DEPTH));
  assign disp_idx   = tail[IW-1:0];
  assign exc_valid  = (count != '0) && e_done[hidx] && e_exc[hidx];
  assign exc_pc     = e_pc[hidx];
  assign disp_fire  = disp_valid && disp_ready && !exc_valid && !flush_valid;

  always_comb begin
    logic go;
    logic [IW-1:0] idx;
    go        = 1'b1;
    nret      = '0;
    ret_valid = '0;
    ret_rd    = '0;
    ret_preg  = '0;
    ret_data  = '0;
    ret_store = '0;
    for (int k = 0; k < RW; k++) begin
      idx = hidx + IW'(k);
      ret_rd[k*AW +: AW]   = e_rd[idx];
      ret_preg[k*PW +: PW] = e_preg[idx];
      ret_data[k*DW +: DW] = e_data[idx];
      ret_store[k]         = e_store[idx];
      if (go && ((IW+1)'(k) < count) && e_done[idx] && !e_exc[idx]) begin
        ret_valid[k] = 1'b1;
        nret         = nret + (IW+1)'(1);
      end else begin
        go = 1'b0;
      end
    end
  end

  always_comb begin
    logic [IW-1:0] idx;
    fl_hit = 1'b0;
    fl_off = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = hidx + IW'(k);
      if (!fl_hit && ((IW+1)'(k) < count) && e_mask[idx][flush_tag]) begin
        fl_hit = 1'b1;
        fl_off = (IW+1)'(k);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      e_done  <= '0;
      e_exc   <= '0;
      e_store <= '0;
    end else begin
      head <= head + nret;
      if (exc_valid)
        tail <= head;
      else if (flush_valid && fl_hit)
        tail <= head + fl_off;
      else if (disp_fire)
        tail <= tail + (IW+1)'(1);
      if (cmp_valid) begin
        e_done[cmp_idx] <= 1'b1;
        e_exc[cmp_idx]  <= cmp_exc;
        e_data[cmp_idx] <= cmp_data;
      end
      if (disp_fire) begin
        e_rd[disp_idx]    <= disp_rd;
        e_preg[disp_idx]  <= disp_preg;
        e_pc[disp_idx]    <= disp_pc;
        e_store[disp_idx] <= disp_store;
        e_mask[disp_idx]  <= disp_mask;
        e_done[disp_idx]  <= 1'b0;
        e_exc[disp_idx]   <= 1'b0;
      end
    end
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= (IW+1)'(DEPTH));
  assert_ret_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((ret_valid + RW'(1)) & ret_valid) == '0);
  assert_head_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid != '0 |=> (head - $past(head)) == (IW+1)'($countones($past(ret_valid))));
  assert_exc_no_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> ret_valid == '0);
  assert_exc_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> count == '0);
  assert_exc_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> tail == $past(head));

endmodule

// File: tb/rob_inorder_tb_top.sv
module rob_inorder_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        disp_valid = 0, disp_store = 0, cmp_valid = 0, cmp_exc = 0, flush_valid = 0;
  logic [4:0]  disp_rd = 0;
  logic [5:0]  disp_preg = 0;
  logic [31:0] disp_pc = 0, cmp_data = 0;
  logic [3:0]  disp_mask = 0, cmp_idx = 0;
  logic [1:0]  flush_tag = 0;
  logic        disp_ready, exc_valid;
  logic [3:0]  disp_idx, ret_valid, ret_store;
  logic [19:0] ret_rd;
  logic [23:0] ret_preg;
  logic [127:0] ret_data;
  logic [31:0] exc_pc;

  int total = 0, bad = 0, cyc = 0;
  logic [43:0] exp_q[$];
  logic [3:0]  ix [128];

  rob_inorder dut_i (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_rd(disp_rd), .disp_preg(disp_preg), .disp_pc(disp_pc),
    .disp_store(disp_store), .disp_mask(disp_mask), .disp_ready(disp_ready), .disp_idx(disp_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
    .flush_valid(flush_valid), .flush_tag(flush_tag),
    .ret_valid(ret_valid), .ret_rd(ret_rd), .ret_preg(ret_preg), .ret_data(ret_data),
    .ret_store(ret_store), .exc_valid(exc_valid), .exc_pc(exc_pc));

  always #5 clk = ~clk;

  function automatic logic [43:0] item(input int n);
    return {5'(n), 6'(n), 32'hC0DE0000 | 32'(n), 1'(n)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic dispatch(input int n, input logic [3:0] mask, input bit will_retire);
    ix[n] = disp_idx;
    disp_valid = 1; disp_rd = 5'(n); disp_preg = 6'(n); disp_pc = 32'(n*4);
    disp_store = 1'(n); disp_mask = mask;
    if (will_retire) exp_q.push_back(item(n));
    @(negedge clk);
    disp_valid = 0; disp_mask = 0;
  endtask

  task automatic complete(input int n, input bit exc);
    cmp_valid = 1; cmp_idx = ix[n]; cmp_data = 32'hC0DE0000 | 32'(n); cmp_exc = exc;
    @(negedge clk);
    cmp_valid = 0; cmp_exc = 0;
  endtask

  // scoreboard monitor: R4 lane order, R6 lane contents
  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        if (ret_valid[k]) begin
          logic [43:0] got, e;
          got = {ret_rd[k*5 +: 5], ret_preg[k*6 +: 6], ret_data[k*32 +: 32], ret_store[k]};
          if (exp_q.size() == 0) begin
            chk(0, "R7", "unexpected retire", 64'(got), 0);
          end else begin
            e = exp_q.pop_front();
            chk(got == e, "R6", "retire lane contents", 64'(got), 64'(e));
          end
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(disp_ready == 1, "R1", "ready", 64'(disp_ready), 1);
    chk(disp_idx == 0, "R1", "idx", 64'(disp_idx), 0);
    chk(ret_valid == 0 && exc_valid == 0, "R1", "retire/exc", 64'({ret_valid, exc_valid}), 0);

    // R2 consecutive slots, R5 gap at head, R4 four-wide retire
    for (int n = 0; n < 6; n++) begin
      dispatch(n, 4'b0000, 1);
      chk(ix[n] == 4'(n), "R2", "slot number", 64'(ix[n]), 64'(n));
    end
    for (int n = 5; n >= 1; n--) complete(n, 0);
    chk(ret_valid == 4'b0000, "R5", "head unfinished", 64'(ret_valid), 0);
    complete(0, 0);
    chk(ret_valid == 4'b1111, "R4", "four lanes", 64'(ret_valid), 64'hF);
    @(negedge clk);
    chk(ret_valid == 4'b0011, "R4", "remaining lanes", 64'(ret_valid), 64'h3);
    @(negedge clk);
    chk(ret_valid == 4'b0000 && disp_idx == 4'd6, "R2", "drained idx", 64'(disp_idx), 6);

    // R3 full, wrapping
    for (int n = 10; n < 26; n++) dispatch(n, 4'b0000, 1);
    chk(disp_ready == 0, "R3", "full ready", 64'(disp_ready), 0);
    disp_valid = 1; disp_rd = 5'd3;
    @(negedge clk);
    disp_valid = 0;
    chk(disp_idx == 4'd6 && disp_ready == 0, "R3", "ignored dispatch idx", 64'(disp_idx), 6);
    for (int n = 13; n < 26; n++) complete(n, 0);
    complete(11, 0);
    complete(10, 0);
    chk(ret_valid == 4'b0011, "R5", "stop at gap", 64'(ret_valid), 64'h3);
    complete(12, 0);
    chk(ret_valid == 4'b1111, "R4", "resume four-wide", 64'(ret_valid), 64'hF);
    repeat (4) @(negedge clk);
    chk(ret_valid == 0 && disp_ready == 1, "R3", "drained", 64'(ret_valid), 0);
    chk(disp_idx == 4'd6, "R3", "no extra slot", 64'(disp_idx), 6);

    // R7 tagged flush, R10 dispatch during flush
    dispatch(30, 4'b0000, 1);
    dispatch(31, 4'b0000, 1);
    dispatch(32, 4'b0100, 0);
    dispatch(33, 4'b0100, 0);
    dispatch(34, 4'b0110, 0);
    flush_valid = 1; flush_tag = 2'd2;
    disp_valid = 1; disp_rd = 5'd9; disp_mask = 4'b0000;
    @(negedge clk);
    flush_valid = 0; disp_valid = 0;
    chk(disp_idx == ix[31] + 4'd1, "R7", "tail after flush", 64'(disp_idx), 64'(ix[31] + 4'd1));
    chk(disp_idx == ix[32], "R10", "flush-cycle dispatch dropped", 64'(disp_idx), 64'(ix[32]));
    dispatch(35, 4'b0000, 1);
    chk(ix[35] == ix[32], "R7", "slot reused", 64'(ix[35]), 64'(ix[32]));
    complete(35, 0);
    complete(31, 0);
    complete(30, 0);
    chk(ret_valid == 4'b0111, "R7", "survivors retire", 64'(ret_valid), 64'h7);
    @(negedge clk);
    chk(ret_valid == 0, "R7", "flushed never retire", 64'(ret_valid), 0);

    // R8 exception at head, R9 priority over flush and dispatch
    dispatch(40, 4'b0000, 1);
    dispatch(41, 4'b0000, 0);
    dispatch(42, 4'b0001, 0);
    dispatch(43, 4'b0001, 0);
    complete(42, 0);
    complete(43, 0);
    complete(41, 1);
    complete(40, 0);
    chk(ret_valid == 4'b0001 && exc_valid == 0, "R8", "older retires first",
        64'({ret_valid, exc_valid}), 64'h2);
    @(negedge clk);
    chk(exc_valid == 1 && ret_valid == 0, "R8", "exception raised", 64'({ret_valid, exc_valid}), 1);
    chk(exc_pc == 32'(41*4), "R8", "exception pc", 64'(exc_pc), 64'(41*4));
    flush_valid = 1; flush_tag = 2'd0; disp_valid = 1; disp_rd = 5'd7;
    @(negedge clk);
    flush_valid = 0; disp_valid = 0;
    chk(exc_valid == 0 && ret_valid == 0, "R8", "exception one cycle", 64'({ret_valid, exc_valid}), 0);
    chk(disp_idx == ix[41], "R9", "buffer emptied at exc slot", 64'(disp_idx), 64'(ix[41]));
    repeat (3) @(negedge clk);
    chk(ret_valid == 0 && disp_ready == 1, "R8", "stays empty", 64'(ret_valid), 0);

    dispatch(50, 4'b0000, 1);
    complete(50, 0);
    chk(ret_valid == 4'b0001, "R2", "operation after exception", 64'(ret_valid), 1);
    @(negedge clk);
    chk(exp_q.size() == 0, "R6", "all expected retired", 64'(exp_q.size()), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule